// File: doc/BRIEF.md
# Binary32 / Brain-Float16 Rounding Converter

This block moves floating-point values between the 32-bit IEEE single-precision layout and the 16-bit brain-float layout. Both layouts share a sign bit and an 8-bit exponent with bias 127. The narrow format keeps only the top 7 of the 23 fraction bits. For narrowing, a 2-bit mode input picks one of three rounding rules: chop, nearest with ties to even, or sticky-odd. For widening, 16 zero bits are appended below the fraction.

Each accepted word goes through a single register stage. The result and two flags appear on the outputs one clock after `in_valid` is sampled high. The flag `out_ovf` marks a finite value that rounding pushed to infinity. The flag `out_inexact` marks a finite value that lost nonzero bits. NaNs always leave the block as quiet NaNs, even when their only payload bits are among the dropped ones. Subnormal values follow the same rounding rules as normal values and are not flushed to zero.

Top module: `bf16_round_conv`

## Requirements
- R1: When narrowing (`in_dir`=0), the result in `out_data[15:0]` keeps the input sign (bit 31) and exponent (bits 30:23) and takes its fraction from input bits 22:16. `out_data[31:16]` is zero. For example, 0x3F800000 gives 0x3F80 and 0xC0000000 gives 0xC000.
- R2: Mode code 0 truncates: the low 16 input bits are dropped. Mode code 3 also truncates.
- R3: Mode code 1 rounds to nearest. Bit 15 is the half bit. On an exact tie (bit 15 set, bits 14:0 zero), the result is the neighbour whose lowest fraction bit is 0.
- R4: Mode code 2 is round-to-odd. If any of input bits 15:0 is 1, the lowest result fraction bit is forced to 1. Otherwise the value passes through exactly.
- R5: `out_ovf` is 1 exactly when a finite input rounds to infinity. The result is then 0x7F80 or 0xFF80 with the input sign. For example, 0x7F7FFFFF in mode 1 gives 0x7F80.
- R6: When narrowing a finite input, `out_inexact` equals the OR of input bits 15:0. It is 0 for NaN and infinity inputs.
- R7: An input with exponent 0xFF and a nonzero fraction gives a NaN that keeps the input sign, has result bit 6 set, and copies input bits 21:16 into result bits 5:0. This holds in every mode.
- R8: Infinities and signed zeros narrow exactly: 0x7F80, 0xFF80, 0x0000 and 0x8000, with both flags 0.
- R9: Subnormal inputs (exponent 0) round by the same rules with no flush. A carry out of the fraction lifts the result to 0x0080.
- R10: When widening (`in_dir`=1), the output is `{in_data[15:0], 16'h0000}` and both flags are 0. NaN payloads and infinities are kept bit for bit.
- R11: `out_data`, `out_ovf` and `out_inexact` update one clock after `in_valid` is sampled high. `out_valid` is `in_valid` delayed by one clock. A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_dir | input | 1 | 0 = narrow binary32 to bf16, 1 = widen bf16 to binary32 |
| in_rmode | input | 2 | Narrowing rule: 0 chop, 1 nearest-even, 2 odd, 3 chop |
| in_data | input | 32 | Binary32 word, or bf16 word in bits 15:0 when widening |
| out_valid | output | 1 | Result present |
| out_data | output | 32 | bf16 in bits 15:0 (upper bits zero), or widened binary32 |
| out_ovf | output | 1 | Finite input rounded to infinity |
| out_inexact | output | 1 | Nonzero bits discarded from a finite input |

## Verification
A wrong guard or sticky extraction shows up as a one-ULP error in the low result bit, or a wrong `out_inexact`, on the very next output cycle. It appears only for inputs with specific dropped-bit patterns, which is why ties and lone sticky bits are driven on purpose. A missed carry into the exponent shows up on the largest finite value and at the top of the subnormal range. A lost NaN marker appears as infinity on the output one cycle later. A broken valid register shows up as `out_valid` that is high or low one cycle out of step with `in_valid`.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int WIDE_W      = 32;
  localparam int NARROW_W    = 16;
  localparam int EXP_W       = 8;
  localparam int WIDE_FRAC   = WIDE_W - 1 - EXP_W;
  localparam int NARROW_FRAC = NARROW_W - 1 - EXP_W;
  localparam int DROP_W      = WIDE_FRAC - NARROW_FRAC;
  localparam int MAG_W       = EXP_W + NARROW_FRAC;

  typedef enum logic [1:0] {
    RM_CHOP = 2'd0,
    RM_NEAR = 2'd1,
    RM_ODD  = 2'd2,
    RM_CHOP2 = 2'd3
  } rmode_e;

  typedef struct packed {
    logic [NARROW_W-1:0] word;
    logic                ovf;
    logic                inexact;
  } nres_t;
endpackage

// File: rtl/bfc_split.sv
module bfc_split
  import bfc_pkg::*;
(
  input  logic [WIDE_W-1:0]      src,
  output logic                   sign,
  output logic [EXP_W-1:0]       expo,
  output logic [NARROW_FRAC-1:0] keep,
  output logic                   half_bit,
  output logic                   sticky,
  output logic                   exp_max,
  output logic                   frac_nz
);
  always_comb begin
    sign     = src[WIDE_W-1];
    expo     = src[WIDE_W-2 -: EXP_W];
    keep     = src[WIDE_FRAC-1 -: NARROW_FRAC];
    half_bit = src[DROP_W-1];
    sticky   = |src[DROP_W-2:0];
    exp_max  = &expo;
    frac_nz  = |src[WIDE_FRAC-1:0];
  end
endmodule

// File: rtl/bfc_narrow.sv
module bfc_narrow
  import bfc_pkg::*;
(
  input  logic                   sign,
  input  logic [EXP_W-1:0]       expo,
  input  logic [NARROW_FRAC-1:0] keep,
  input  logic                   half_bit,
  input  logic                   sticky,
  input  logic                   exp_max,
  input  logic                   frac_nz,
  input  rmode_e                 rmode,
  output nres_t                  res
);
  logic [MAG_W-1:0] mag_in, mag_sum, mag_fin;
  logic             bump, force_odd, lost;

  always_comb begin
    mag_in    = {expo, keep};
    lost      = half_bit | sticky;
    bump      = 1'b0;
    force_odd = 1'b0;
    case (rmode)
      RM_NEAR: bump      = half_bit & (sticky | keep[0]);
      RM_ODD:  force_odd = lost;
      default: ;
    endcase
    mag_sum = mag_in + MAG_W'(bump);
    mag_fin = mag_sum | MAG_W'(force_odd);

    if (exp_max && frac_nz) begin
      res.word    = {sign, {EXP_W{1'b1}}, 1'b1, keep[NARROW_FRAC-2:0]};
      res.ovf     = 1'b0;
      res.inexact = 1'b0;
    end else if (exp_max) begin
      res.word    = {sign, expo, keep};
      res.ovf     = 1'b0;
      res.inexact = 1'b0;
    end else begin
      res.word    = {sign, mag_fin};
      res.ovf     = &mag_fin[MAG_W-1:NARROW_FRAC];
      res.inexact = lost;
    end
  end
endmodule

// File: rtl/bfc_widen.sv
module bfc_widen
  import bfc_pkg::*;
(
  input  logic [NARROW_W-1:0] src,
  output logic [WIDE_W-1:0]   dst
);
  assign dst = {src, {DROP_W{1'b0}}};
endmodule

// File: rtl/bf16_round_conv.sv
module bf16_round_conv
  import bfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_dir,
  input  logic [1:0]        in_rmode,
  input  logic [WIDE_W-1:0] in_data,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_data,
  output logic              out_ovf,
  output logic              out_inexact
);
  logic                   s_sign, s_half, s_sticky, s_emax, s_fnz;
  logic [EXP_W-1:0]       s_exp;
  logic [NARROW_FRAC-1:0] s_keep;
  nres_t                  n_res;
  logic [WIDE_W-1:0]      w_res;
  logic [WIDE_W-1:0]      nxt_data;
  logic                   nxt_ovf, nxt_inx;

  bfc_split u_split (
    .src(in_data), .sign(s_sign), .expo(s_exp), .keep(s_keep),
    .half_bit(s_half), .sticky(s_sticky), .exp_max(s_emax), .frac_nz(s_fnz)
  );

  bfc_narrow u_narrow (
    .sign(s_sign), .expo(s_exp), .keep(s_keep), .half_bit(s_half),
    .sticky(s_sticky), .exp_max(s_emax), .frac_nz(s_fnz),
    .rmode(rmode_e'(in_rmode)), .res(n_res)
  );

  bfc_widen u_widen (.src(in_data[NARROW_W-1:0]), .dst(w_res));

  always_comb begin
    if (in_dir) begin
      nxt_data = w_res;
      nxt_ovf  = 1'b0;
      nxt_inx  = 1'b0;
    end else begin
      nxt_data = {{(WIDE_W-NARROW_W){1'b0}}, n_res.word};
      nxt_ovf  = n_res.ovf;
      nxt_inx  = n_res.inexact;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_ovf     <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= nxt_data;
        out_ovf     <= nxt_ovf;
        out_inexact <= nxt_inx;
      end
    end
  end

  assert_valid_rise_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_ovf_is_inf_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf) |-> (out_data[NARROW_W-2:0] == {{EXP_W{1'b1}}, {NARROW_FRAC{1'b0}}}));
  assert_ovf_inexact_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf) |-> out_inexact);
  assert_widen_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_dir) |=> (!out_ovf && !out_inexact && out_data[DROP_W-1:0] == '0));
  assert_nan_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_dir && (&in_data[WIDE_W-2 -: EXP_W]) && (|in_data[WIDE_FRAC-1:0]))
      |=> out_data[NARROW_FRAC-1]);
endmodule

// File: tb/bf16_round_conv_tb_top.sv
module bf16_round_conv_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic rst, in_valid, in_dir;
  logic [1:0] in_rmode;
  logic [31:0] in_data;
  logic out_valid, out_ovf, out_inexact;
  logic [31:0] out_data;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bf16_round_conv dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dir(in_dir),
    .in_rmode(in_rmode), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_ovf(out_ovf), .out_inexact(out_inexact)
  );

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one transaction: drive at negedge, sample at the following negedge
  task automatic xfer(input string tag, input logic dir, input logic [1:0] m,
                      input logic [31:0] d, input logic [31:0] ew,
                      input logic eo, input logic ei);
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_rmode = m; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, {out_valid, out_ovf, out_inexact, out_data}, {1'b1, eo, ei, ew});
  endtask

  task automatic t_reset;
    chk("R11 reset", {32'b0, out_valid, out_ovf, out_inexact}, 35'b0);
  endtask

  task automatic t_exact;
    xfer("R1 one", 0, 2'd1, 32'h3F800000, 32'h3F80, 0, 0);
    xfer("R1 minus two", 0, 2'd0, 32'hC0000000, 32'hC000, 0, 0);
    xfer("R1 pi", 0, 2'd2, 32'h40490000, 32'h4049, 0, 0);
  endtask

  task automatic t_chop;
    xfer("R2 chop max", 0, 2'd0, 32'h7F7FFFFF, 32'h7F7F, 0, 1);
    xfer("R2 chop mode3", 0, 2'd3, 32'hBF80FFFF, 32'hBF80, 0, 1);
  endtask

  task automatic t_near;
    xfer("R3 tie even down", 0, 2'd1, 32'h3F808000, 32'h3F80, 0, 1);
    xfer("R3 tie odd up", 0, 2'd1, 32'h3F818000, 32'h3F82, 0, 1);
    xfer("R3 above half", 0, 2'd1, 32'h3F808001, 32'h3F81, 0, 1);
    xfer("R3 below half", 0, 2'd1, 32'hBF807FFF, 32'hBF80, 0, 1);
  endtask

  task automatic t_odd;
    xfer("R4 sticky sets lsb", 0, 2'd2, 32'h3F800001, 32'h3F81, 0, 1);
    xfer("R4 exact odd kept", 0, 2'd2, 32'h3F810000, 32'h3F81, 0, 0);
    xfer("R4 no overflow", 0, 2'd2, 32'h7F7FFFFF, 32'h7F7F, 0, 1);
  endtask

  task automatic t_ovf;
    xfer("R5 pos to inf", 0, 2'd1, 32'h7F7FFFFF, 32'h7F80, 1, 1);
    xfer("R5 neg to inf", 0, 2'd1, 32'hFF7F8000, 32'hFF80, 1, 1);
    xfer("R6 exact no flags", 0, 2'd1, 32'h7F7F0000, 32'h7F7F, 0, 0);
  endtask

  task automatic t_nan;
    xfer("R7 low payload chop", 0, 2'd0, 32'h7F800001, 32'h7FC0, 0, 0);
    xfer("R7 neg low payload", 0, 2'd1, 32'hFF800001, 32'hFFC0, 0, 0);
    xfer("R7 payload kept", 0, 2'd2, 32'h7FA10000, 32'h7FE1, 0, 0);
  endtask

  task automatic t_special;
    xfer("R8 pos inf", 0, 2'd1, 32'h7F800000, 32'h7F80, 0, 0);
    xfer("R8 neg inf", 0, 2'd2, 32'hFF800000, 32'hFF80, 0, 0);
    xfer("R8 pos zero", 0, 2'd1, 32'h00000000, 32'h0000, 0, 0);
    xfer("R8 neg zero", 0, 2'd0, 32'h80000000, 32'h8000, 0, 0);
  endtask

  task automatic t_sub;
    xfer("R9 carry to normal", 0, 2'd1, 32'h007FFFFF, 32'h0080, 0, 1);
    xfer("R9 tiny odd", 0, 2'd2, 32'h80000001, 32'h8001, 0, 1);
    xfer("R9 tiny chop", 0, 2'd0, 32'h00000001, 32'h0000, 0, 1);
  endtask

  task automatic t_widen;
    xfer("R10 one", 1, 2'd1, 32'hFFFF3F80, 32'h3F800000, 0, 0);
    xfer("R10 nan", 1, 2'd0, 32'h0000FF81, 32'hFF810000, 0, 0);
    xfer("R10 neg inf", 1, 2'd2, 32'h0000FF80, 32'hFF800000, 0, 0);
  endtask

  task automatic t_valid;
    @(negedge clk);
    chk("R11 idle low", {34'b0, out_valid}, 35'b0);
    in_valid = 1'b1; in_dir = 1'b0; in_rmode = 2'd0; in_data = 32'h40000000;
    @(negedge clk);
    in_valid = 1'b0; in_data = 32'h3F800000;
    chk("R11 one cycle", {out_valid, 2'b0, out_data}, {1'b1, 2'b0, 32'h4000});
    @(negedge clk);
    chk("R11 drop and hold", {out_valid, 2'b0, out_data}, {1'b0, 2'b0, 32'h4000});
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    chk("R11 reset clears", {34'b0, out_valid}, 35'b0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_dir = 1'b0; in_rmode = 2'd0; in_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_exact(); t_chop(); t_near(); t_odd(); t_ovf();
    t_nan(); t_special(); t_sub(); t_widen(); t_valid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule